// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is the host side of a three-wire read from a two-channel, 10-bit successive-approximation converter. The serial clock idles low and data is captured on its rising edge. When the host raises `start_i`, the block drops chip-select while the serial clock is low, which puts the converter in external-clock mode. It then waits a programmable wake-up time and runs sixteen serial clock cycles. Each incoming bit is taken on a rising edge, because the converter moves its data line on falling edges.

When the frame is complete, chip-select is raised on the sixteenth falling edge. At the same moment the block publishes the channel bit, the 10-bit result and the two sub-LSB bits, together with a one-cycle done pulse and a flag that reports a bad leading-ones header. Chip-select is then held high for a programmable gap before another start is accepted. An abort input ends a read at once, and the same gap still applies afterwards.

All timing comes from counts of system clocks. The wake-up time, the deselect gap and the serial clock half-period are each a programmable count. Choosing these counts so that they meet the converter's wake-up time, its minimum deselect time and its allowed serial clock range is left to the integrator.

Top module: `adcrd_host`

## Requirements
- R1: After reset and while idle, `adc_cs_n_o` is 1 and `adc_sclk_o` is 0. A `start_i` seen while idle drives `adc_cs_n_o` low on the next clock, with `adc_sclk_o` low. Whenever `adc_cs_n_o` is high, `adc_sclk_o` is 0.
- R2: The first rising edge of `adc_sclk_o` comes exactly `wake_cycles_i + half_cycles_i + 2` system clocks after `adc_cs_n_o` falls.
- R3: Every high phase and every low phase of `adc_sclk_o` lasts `half_cycles_i + 1` system clocks. Each read has exactly 16 rising edges.
- R4: A bit is taken from `adc_miso_i` at each rising edge, first bit first. The 4th bit appears on `chan_id_o`. Bits 5 to 14 appear on `data_o`, with bit 5 as `data_o[9]`. Bits 15 and 16 appear on `sub_o[1]` and `sub_o[0]`.
- R5: `hdr_err_o` is 1 exactly when any of the first three received bits is 0. All result outputs change only in the cycle where `done_o` is high, and they hold their values otherwise.
- R6: The 16th falling edge of `adc_sclk_o` happens in the same clock as the rise of `adc_cs_n_o` and a done pulse that lasts a single cycle, and the results are valid in that cycle.
- R7: After `adc_cs_n_o` rises, `busy_o` stays high for exactly `gap_cycles_i + 1` clocks. A `start_i` seen while `busy_o` is high is ignored.
- R8: An `abort_i` seen while `busy_o` is high and `adc_cs_n_o` is low raises `adc_cs_n_o` and holds `adc_sclk_o` low on the next clock. In that case no `done_o` is produced, and `busy_o` then stays high for `gap_cycles_i + 1` clocks. An `abort_i` seen while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one read |
| abort_i | input | 1 | End the current read at once |
| wake_cycles_i | input | WAKE_W | Wake-up wait count |
| gap_cycles_i | input | GAP_W | Deselect gap count |
| half_cycles_i | input | DIV_W | Serial clock half-period count |
| adc_miso_i | input | 1 | Serial data from the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_cs_n_o | output | 1 | Active-low chip-select |
| busy_o | output | 1 | A read or a gap is in progress |
| done_o | output | 1 | One-cycle pulse when results are published |
| hdr_err_o | output | 1 | Leading-ones header was wrong |
| chan_id_o | output | 1 | Received channel bit |
| data_o | output | 10 | Received conversion result |
| sub_o | output | 2 | Received sub-LSB bits |

## Verification
The assertions check, on every cycle, the relations between the pins and the control lines. The serial clock is low whenever chip-select is high, and chip-select falls only from idle. Done lasts one cycle and comes with the rise of chip-select. The result outputs stay still between done pulses. An abort always deselects without producing done, and a start during the gap leaves chip-select high. Other properties depend on the programmed counts or on the data received, and only the bench scenarios can show them: the exact wake-up latency, the phase lengths, the count of sixteen edges, the length of the gap, and the decoding of the header, channel, result and sub-bits.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int FRAME_BITS = 16;
  localparam int HDR_BITS   = 3;
  localparam int DATA_BITS  = 10;
  localparam int SUB_BITS   = 2;
  localparam int CHAN_POS   = FRAME_BITS - HDR_BITS - 1;
  localparam int EDGE_W     = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAKE  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_e;

  typedef struct packed {
    logic                 hdr_err;
    logic                 chan;
    logic [DATA_BITS-1:0] data;
    logic [SUB_BITS-1:0]  sub;
  } rd_result_s;
endpackage

// File: rtl/adcrd_reset_sync.sv
module adcrd_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/adcrd_delay.sv
module adcrd_delay #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                     cnt_d = load_val_i;
    else if (run_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen
  import adcrd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             last_fall_o
);
  logic [DIV_W-1:0]  hc_q, hc_d;
  logic              sclk_q, sclk_d;
  logic [EDGE_W-1:0] nfall_q, nfall_d;
  logic              toggle;

  assign toggle      = en_i && !clear_i && (hc_q == '0);
  assign rise_o      = toggle && !sclk_q;
  assign last_fall_o = toggle && sclk_q && (nfall_q == EDGE_W'(FRAME_BITS - 1));

  always_comb begin
    hc_d    = hc_q;
    sclk_d  = sclk_q;
    nfall_d = nfall_q;
    if (clear_i) begin
      hc_d    = half_i;
      sclk_d  = 1'b0;
      nfall_d = '0;
    end else if (en_i) begin
      if (hc_q == '0) begin
        hc_d   = half_i;
        sclk_d = ~sclk_q;
        if (sclk_q) nfall_d = nfall_q + 1'b1;
      end else begin
        hc_d = hc_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q    <= '0;
      sclk_q  <= 1'b0;
      nfall_q <= '0;
    end else begin
      hc_q    <= hc_d;
      sclk_q  <= sclk_d;
      nfall_q <= nfall_d;
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/adcrd_frame_rx.sv
module adcrd_frame_rx
  import adcrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_i,
  input  logic       bit_i,
  input  logic       publish_i,
  output rd_result_s result_o,
  output logic       done_o
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  rd_result_s            res_q, res_d;
  logic                  done_q;
  logic [HDR_BITS-1:0]   hdr_ok;

  for (genvar i = 0; i < HDR_BITS; i++) begin : g_hdr
    assign hdr_ok[i] = sh_q[FRAME_BITS-1-i];
  end

  always_comb begin
    sh_d = sh_q;
    if (shift_i) sh_d = {sh_q[FRAME_BITS-2:0], bit_i};
  end

  always_comb begin
    res_d = res_q;
    if (publish_i) begin
      res_d.hdr_err = ~&hdr_ok;
      res_d.chan    = sh_q[CHAN_POS];
      res_d.data    = sh_q[SUB_BITS +: DATA_BITS];
      res_d.sub     = sh_q[SUB_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      res_q  <= res_d;
      done_q <= publish_i;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/adcrd_host.sv
module adcrd_host
  import adcrd_pkg::*;
#(
  parameter int WAKE_W = 16,
  parameter int GAP_W  = 8,
  parameter int DIV_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  logic [WAKE_W-1:0]    wake_cycles_i,
  input  logic [GAP_W-1:0]     gap_cycles_i,
  input  logic [DIV_W-1:0]     half_cycles_i,
  input  logic                 adc_miso_i,
  output logic                 adc_sclk_o,
  output logic                 adc_cs_n_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 hdr_err_o,
  output logic                 chan_id_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic [SUB_BITS-1:0]  sub_o
);
  localparam int TMR_W = (WAKE_W > GAP_W) ? WAKE_W : GAP_W;

  logic             rst_sn;
  rd_state_e        state_q, state_d;
  logic             cs_n_q, cs_n_d;
  logic             tmr_load, tmr_run, tmr_zero;
  logic [TMR_W-1:0] tmr_val, wake_ext, gap_ext;
  logic             gen_clear, gen_en, gen_rise, gen_last_fall;
  logic             publish;
  rd_result_s       result;

  assign wake_ext = TMR_W'(wake_cycles_i);
  assign gap_ext  = TMR_W'(gap_cycles_i);

  adcrd_reset_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sn)
  );

  always_comb begin
    state_d  = state_q;
    cs_n_d   = cs_n_q;
    tmr_load = 1'b0;
    tmr_val  = gap_ext;
    publish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_WAKE;
          cs_n_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = wake_ext;
        end
      end
      ST_WAKE: begin
        if (abort_i) begin
          state_d  = ST_GAP;
          cs_n_d   = 1'b1;
          tmr_load = 1'b1;
        end else if (tmr_zero) begin
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (abort_i) begin
          state_d  = ST_GAP;
          cs_n_d   = 1'b1;
          tmr_load = 1'b1;
        end else if (gen_last_fall) begin
          state_d  = ST_GAP;
          cs_n_d   = 1'b1;
          tmr_load = 1'b1;
          publish  = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cs_n_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign tmr_run   = (state_q == ST_WAKE) || (state_q == ST_GAP);
  assign gen_en    = (state_q == ST_SHIFT);
  assign gen_clear = (state_q != ST_SHIFT) || abort_i;

  adcrd_delay #(.CNT_W(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_sn),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .zero_o     (tmr_zero)
  );

  adcrd_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk         (clk),
    .rst_n       (rst_sn),
    .clear_i     (gen_clear),
    .en_i        (gen_en),
    .half_i      (half_cycles_i),
    .sclk_o      (adc_sclk_o),
    .rise_o      (gen_rise),
    .last_fall_o (gen_last_fall)
  );

  adcrd_frame_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_sn),
    .shift_i   (gen_rise),
    .bit_i     (adc_miso_i),
    .publish_i (publish),
    .result_o  (result),
    .done_o    (done_o)
  );

  assign adc_cs_n_o = cs_n_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign hdr_err_o  = result.hdr_err;
  assign chan_id_o  = result.chan;
  assign data_o     = result.data;
  assign sub_o      = result.sub;
endmodule

// File: rtl/adcrd_host_chk.sv
module adcrd_host_chk
  import adcrd_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 abort,
  input logic                 cs_n,
  input logic                 sclk,
  input logic                 busy,
  input logic                 done,
  input logic                 hdr_err,
  input logic                 chan,
  input logic [DATA_BITS-1:0] data,
  input logic [SUB_BITS-1:0]  sub
);
  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R1
  AST_CS_FALL_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (!sclk && !$past(busy))); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_WITH_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(cs_n) && !sclk)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({hdr_err, chan, data, sub})); // R5
  AST_ABORT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy && !cs_n) |=> (cs_n && !sclk && !done && busy)); // R8
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && cs_n) |=> cs_n); // R7
endmodule

bind adcrd_host adcrd_host_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start_i),
  .abort   (abort_i),
  .cs_n    (adc_cs_n_o),
  .sclk    (adc_sclk_o),
  .busy    (busy_o),
  .done    (done_o),
  .hdr_err (hdr_err_o),
  .chan    (chan_id_o),
  .data    (data_o),
  .sub     (sub_o)
);

// File: tb/adcrd_host_test.sv
`timescale 1ns/1ps
module adcrd_host_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, abort_i;
  logic [15:0] wake_cfg;
  logic [7:0]  gap_cfg, half_cfg;
  logic        miso;
  logic        adc_sclk_o, adc_cs_n_o, busy_o, done_o, hdr_err_o, chan_id_o;
  logic [9:0]  data_o;
  logic [1:0]  sub_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model_frame = 16'hFFFF;
  int          model_idx = 0;

  always #2.5 clk = ~clk;

  adcrd_host uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .wake_cycles_i(wake_cfg), .gap_cycles_i(gap_cfg), .half_cycles_i(half_cfg),
    .adc_miso_i(miso), .adc_sclk_o(adc_sclk_o), .adc_cs_n_o(adc_cs_n_o),
    .busy_o(busy_o), .done_o(done_o), .hdr_err_o(hdr_err_o),
    .chan_id_o(chan_id_o), .data_o(data_o), .sub_o(sub_o)
  );

  // Converter model: first bit on select, next bit after each falling edge
  always @(negedge adc_cs_n_o) begin
    model_idx = 0;
    miso = model_frame[15];
  end
  always @(negedge adc_sclk_o) begin
    if (adc_cs_n_o === 1'b0) begin
      model_idx = model_idx + 1;
      miso = (model_idx < 16) ? model_frame[15 - model_idx] : 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_hdr_err(input logic [15:0] f);
    return f[15:13] != 3'b111;
  endfunction

  task automatic run_conv(input logic [15:0] frm, input int w, input int h,
                          input int g, input bit poke);
    int n = 0, first_rise = -1, rises = 0, last_edge = 0, phase_bad = 0, m = 0;
    bit got_done = 0;
    logic prev_s = 1'b0;
    logic cap_err = 1'b0, cap_ch = 1'b0;
    logic [9:0] cap_d = '0;
    logic [1:0] cap_s = '0;
    wake_cfg = 16'(w); half_cfg = 8'(h); gap_cfg = 8'(g); model_frame = frm;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(adc_cs_n_o == 1'b0 && adc_sclk_o == 1'b0, "R1", "select after start",
        int'(adc_cs_n_o), 0);
    while (!got_done && n < 5000) begin
      @(negedge clk); n++;
      if (adc_sclk_o && !prev_s) begin
        rises++;
        if (first_rise < 0) first_rise = n;
        else if (n - last_edge != h + 1) phase_bad++;
        last_edge = n;
      end else if (!adc_sclk_o && prev_s) begin
        if (n - last_edge != h + 1) phase_bad++;
        last_edge = n;
      end
      if (done_o) begin
        got_done = 1;
        cap_err = hdr_err_o; cap_ch = chan_id_o; cap_d = data_o; cap_s = sub_o;
        chk(adc_cs_n_o == 1'b1 && last_edge == n, "R6", "deselect on 16th fall",
            int'(adc_cs_n_o), 1);
      end
      prev_s = adc_sclk_o;
    end
    chk(first_rise == w + h + 2, "R2", "wake latency", first_rise, w + h + 2);
    chk(rises == 16, "R3", "rising edges", rises, 16);
    chk(phase_bad == 0, "R3", "phase length errors", phase_bad, 0);
    chk(got_done, "R6", "done seen", int'(got_done), 1);
    chk(cap_ch == frm[12], "R4", "channel bit", int'(cap_ch), int'(frm[12]));
    chk(cap_d == frm[11:2], "R4", "data", int'(cap_d), int'(frm[11:2]));
    chk(cap_s == frm[1:0], "R4", "sub bits", int'(cap_s), int'(frm[1:0]));
    chk(cap_err == exp_hdr_err(frm), "R5", "header flag", int'(cap_err),
        int'(exp_hdr_err(frm)));
    if (poke) start_i = 1'b1;
    while (busy_o && m < 5000) begin
      @(negedge clk); m++;
      start_i = 1'b0;
      if (!busy_o) break;
    end
    chk(m == g + 1, "R7", "gap length", m, g + 1);
    @(negedge clk);
    chk(adc_cs_n_o && !busy_o, "R7", "start in gap ignored", int'(busy_o), 0);
    chk(hdr_err_o == cap_err && data_o == cap_d, "R5", "results held",
        int'(data_o), int'(cap_d));
  endtask

  task automatic run_abort(input int w, input int h, input int g, input int k);
    int m = 0;
    bit saw_done = 0;
    wake_cfg = 16'(w); half_cfg = 8'(h); gap_cfg = 8'(g);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (k) begin @(negedge clk); if (done_o) saw_done = 1; end
    abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    chk(adc_cs_n_o && !adc_sclk_o && busy_o, "R8", "abort deselects",
        int'(adc_cs_n_o), 1);
    while (busy_o && m < 5000) begin
      @(negedge clk); m++;
      if (done_o) saw_done = 1;
    end
    chk(!saw_done, "R8", "no done after abort", int'(saw_done), 0);
    chk(m == g + 1, "R8", "gap after abort", m, g + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0;
    wake_cfg = 16'd3; gap_cfg = 8'd2; half_cfg = 8'd1;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(adc_cs_n_o && !adc_sclk_o && !busy_o && !done_o, "R1", "reset state",
        int'(adc_cs_n_o), 1);

    // Directed corners
    run_conv(16'hE000 | (10'h3FF << 2) | 16'h1002, 0, 0, 0, 0);
    run_conv(16'hE000 | 16'h0001, 5, 2, 3, 1);
    run_conv(16'h6FFF, 2, 1, 1, 0);   // first header bit low
    run_conv(16'hC555, 1, 3, 4, 1);   // third header bit low
    run_conv(16'hF2AA, 40, 4, 12, 0);

    // Abort in idle has no effect
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    chk(adc_cs_n_o && !busy_o, "R8", "abort while idle", int'(busy_o), 0);

    // Abort while waking and while shifting
    run_abort(10, 1, 3, 3);
    run_abort(0, 2, 0, 12);
    run_abort(2, 0, 5, 20);

    // Random reads
    for (int i = 0; i < 24; i++) begin
      logic [15:0] f;
      f = 16'($urandom);
      if ($urandom_range(0, 3) != 0) f[15:13] = 3'b111;
      run_conv(f, int'($urandom_range(0, 20)), int'($urandom_range(0, 5)),
               int'($urandom_range(0, 10)), bit'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule